// File: doc/BRIEF.md
# Clock Reference Status Qualifier

This block sits between the raw health monitors of four candidate clock references and the algorithm that picks one of them. For every channel it turns a noisy signal-present bit and a deviation-fault pulse into one steady "usable" flag. Short dropouts are held off, and a reference that returns must stay present for a settling time before it is trusted again. A frequency fault stays set until software clears it, even if the deviation goes away. The block does not measure deviation and does not choose among channels.

Timing is counted in pulses of a shared `tick` strobe, not in clock cycles. Two 16-bit lengths are shared by all channels: a holdoff length H for losses and a wait-to-restore length W for recoveries. A value of zero means the change happens on the first tick.

Each channel runs a presence state machine with four states:
- LOST: the reference is absent. LOST moves to RESTORE when the signal returns.
- RESTORE: the reference is back but not yet trusted. RESTORE moves to UP on the W+1-th tick, and falls back to LOST if the signal drops.
- UP: the reference is trusted. UP moves to HOLDOFF when the signal drops.
- HOLDOFF: the signal is gone, but the reference is still reported present. HOLDOFF moves to LOST on the H+1-th tick, and returns to UP if the signal comes back.

Every entry into RESTORE or HOLDOFF restarts the tick count at zero. Only ticks sampled while the channel is already in RESTORE or HOLDOFF are counted.

A second state machine per channel tracks the deviation status:
- NORMAL moves to FAULT when an enabled deviation pulse arrives.
- FAULT moves back to NORMAL when a recover strobe arrives without a simultaneous enabled deviation pulse.

Top module: `clk_ref_qualifier`

## Requirements
- R1: After a channel's signal drops, `present_q` stays 1 and falls to 0 only on the clock edge carrying the H+1-th tick seen with the signal continuously low; it never falls on an edge without a tick.
- R2: A loss that ends before the H+1-th tick leaves `present_q`, `dev_latched` and `usable` unchanged.
- R3: After a lost channel's signal returns, `present_q` rises only on the edge carrying the W+1-th tick seen with the signal continuously high.
- R4: If the signal drops while a channel is in RESTORE, the channel goes back to LOST, stays not present, and the restore count starts again from zero.
- R5: If the signal returns while a channel is in HOLDOFF, the channel stays present, and the holdoff count starts again from zero at the next loss.
- R6: A `dev_bad` pulse sets `dev_latched` on the next edge only when both `det_en` and `sw_en` are 1.
- R7: A set `dev_latched` clears only through that channel's `recover` bit. It is not cleared by the deviation going away, by dropping the enables, or by another channel's `recover` bit.
- R8: A `recover` strobe on a channel in NORMAL changes nothing. When `recover` and an enabled `dev_bad` arrive in the same cycle, `dev_latched` ends up set.
- R9: `usable` is 1 exactly when `present_q` is 1 and `dev_latched` is 0 for that channel.
- R10: After reset, every channel is in LOST and NORMAL with its timers cleared, so all outputs are 0.
- R11: Bit i of every per-channel port belongs to channel i. Stimulus on one channel changes no other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base strobe; holdoff and restore lengths count these pulses |
| sig_ok | input | 4 | Raw signal-present bit per channel |
| dev_bad | input | 4 | Frequency deviation fault pulse per channel |
| det_en | input | 1 | Global deviation detection enable |
| sw_en | input | 1 | Global deviation-triggered switching enable |
| recover | input | 4 | Per-channel strobe that clears a latched deviation fault |
| holdoff_len | input | 16 | Holdoff length H in ticks (fall on tick H+1) |
| wtr_len | input | 16 | Wait-to-restore length W in ticks (rise on tick W+1) |
| present_q | output | 4 | Qualified presence per channel |
| dev_latched | output | 4 | Latched deviation fault per channel |
| usable | output | 4 | Present and free of deviation fault, per channel |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a deviation set and a recover clear. The bench drives `dev_bad` and `recover` on the same channel in the same cycle with both enables on. It passes only if the fault ends up latched and `usable` stays low.

The second pair is a signal return and a counting tick, which collide during HOLDOFF and RESTORE. The bench sweeps every H and W from 0 to 3 on every channel. It interrupts each window one tick short of expiry and checks that the next window needs the full H+1 or W+1 ticks again.

// File: rtl/clkq_pkg.sv
package clkq_pkg;

    // Presence qualification states
    typedef enum logic [1:0] {
        PS_LOST    = 2'd0,
        PS_RESTORE = 2'd1,
        PS_UP      = 2'd2,
        PS_HOLDOFF = 2'd3
    } pres_state_t;

    // Deviation status states
    typedef enum logic {
        DV_NORMAL = 1'b0,
        DV_FAULT  = 1'b1
    } dev_state_t;

endpackage

// File: rtl/clkq_presence_fsm.sv
module clkq_presence_fsm
    import clkq_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sig_ok,
    input  logic [TMR_W-1:0] holdoff_len,
    input  logic [TMR_W-1:0] wtr_len,
    output logic             present_o
);

    pres_state_t      st_q, st_d;
    logic [TMR_W-1:0] cnt_q, cnt_d;

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_LOST;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PS_LOST: begin
                if (sig_ok) begin
                    st_d  = PS_RESTORE;
                    cnt_d = '0;
                end
            end
            PS_RESTORE: begin
                if (!sig_ok) begin
                    st_d  = PS_LOST;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q >= wtr_len) begin
                        st_d  = PS_UP;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PS_UP: begin
                if (!sig_ok) begin
                    st_d  = PS_HOLDOFF;
                    cnt_d = '0;
                end
            end
            PS_HOLDOFF: begin
                if (sig_ok) begin
                    st_d  = PS_UP;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q >= holdoff_len) begin
                        st_d  = PS_LOST;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = PS_LOST;
                cnt_d = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            PS_UP, PS_HOLDOFF: present_o = 1'b1;
            default:           present_o = 1'b0;
        endcase
    end

    // R1 / R2: presence never falls without a tick
    assert_hold_until_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (present_o && !tick) |=> present_o);

    // R5: presence never falls while the signal is there
    assert_no_loss_with_signal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (present_o && sig_ok) |=> present_o);

    // R3: presence never rises without a tick
    assert_restore_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!present_o && !tick) |=> !present_o);

    // R4: presence never rises while the signal is missing
    assert_no_restore_without_signal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!present_o && !sig_ok) |=> !present_o);

endmodule

// File: rtl/clkq_dev_latch.sv
module clkq_dev_latch
    import clkq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic sw_en,
    input  logic dev_bad,
    input  logic recover,
    output logic fault_o
);

    dev_state_t st_q, st_d;
    logic       arm;

    assign arm = det_en & sw_en & dev_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DV_NORMAL;
        else        st_q <= st_d;
    end

    // A new fault outranks a simultaneous recover
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_NORMAL: if (arm)             st_d = DV_FAULT;
            DV_FAULT:  if (recover && !arm) st_d = DV_NORMAL;
            default:                        st_d = DV_NORMAL;
        endcase
    end

    always_comb begin
        unique case (st_q)
            DV_FAULT: fault_o = 1'b1;
            default:  fault_o = 1'b0;
        endcase
    end

    // R6: no latch unless both enables are on
    assert_latch_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_o && !(det_en && sw_en)) |=> !fault_o);

    // R7: fault clears only through recover
    assert_clear_by_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !recover) |=> fault_o);

    // R8: simultaneous fault and recover leaves the fault set
    assert_fault_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && dev_bad && det_en && sw_en) |=> fault_o);

endmodule

// File: rtl/clk_ref_qualifier.sv
module clk_ref_qualifier
    import clkq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] sig_ok,
    input  logic [NUM_CH-1:0] dev_bad,
    input  logic              det_en,
    input  logic              sw_en,
    input  logic [NUM_CH-1:0] recover,
    input  logic [TMR_W-1:0]  holdoff_len,
    input  logic [TMR_W-1:0]  wtr_len,
    output logic [NUM_CH-1:0] present_q,
    output logic [NUM_CH-1:0] dev_latched,
    output logic [NUM_CH-1:0] usable
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        clkq_presence_fsm #(.TMR_W(TMR_W)) pres_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .sig_ok     (sig_ok[ch]),
            .holdoff_len(holdoff_len),
            .wtr_len    (wtr_len),
            .present_o  (present_q[ch])
        );

        clkq_dev_latch dev_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .det_en (det_en),
            .sw_en  (sw_en),
            .dev_bad(dev_bad[ch]),
            .recover(recover[ch]),
            .fault_o(dev_latched[ch])
        );

        // R9: combined qualification
        assign usable[ch] = present_q[ch] & ~dev_latched[ch];

        // R9: the usable flag never falls through a change in deviation status alone
        assert_usable_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (usable[ch] && !dev_bad[ch] && present_q[ch]) |=> (dev_latched[ch] == 1'b0));
    end

endmodule

// File: tb/clk_ref_qualifier_tb_top.sv
module clk_ref_qualifier_tb_top;

    localparam int N  = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic [N-1:0]  sig_ok, dev_bad, recover;
    logic          det_en, sw_en;
    logic [TW-1:0] holdoff_len, wtr_len;
    logic [N-1:0]  present_q, dev_latched, usable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clk_ref_qualifier #(.NUM_CH(N), .TMR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sig_ok(sig_ok), .dev_bad(dev_bad),
        .det_en(det_en), .sw_en(sw_en), .recover(recover),
        .holdoff_len(holdoff_len), .wtr_len(wtr_len),
        .present_q(present_q), .dev_latched(dev_latched), .usable(usable)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // All stimulus runs at falling edges; one tick pulse spans one rising edge
    task automatic tick1();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic others_idle(input int ch, input string req);
        for (int k = 0; k < N; k++)
            if (k != ch) chk(present_q[k], 1'b0, req, $sformatf("ch%0d untouched", k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; sig_ok = '1; dev_bad = '0; recover = '0;
        det_en = 1'b0; sw_en = 1'b0; holdoff_len = '0; wtr_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, signal present but no tick yet
        for (int k = 0; k < N; k++) begin
            chk(present_q[k], 1'b0, "R10", "present after reset");
            chk(dev_latched[k], 1'b0, "R10", "deviation after reset");
            chk(usable[k], 1'b0, "R10", "usable after reset");
        end
        sig_ok = '0;
        @(negedge clk);

        // Timer sweep over channels and lengths
        for (int ch = 0; ch < N; ch++) begin
            for (int h = 0; h < 4; h++) begin
                for (int w = 0; w < 4; w++) begin
                    holdoff_len = TW'(h);
                    wtr_len     = TW'(w);
                    sig_ok      = '0;
                    @(negedge clk);
                    repeat (8) tick1();
                    chk(present_q[ch], 1'b0, "R1", "start lost");

                    // R3: restore window
                    sig_ok[ch] = 1'b1;
                    @(negedge clk);
                    for (int t = 1; t <= w + 1; t++) begin
                        tick1();
                        chk(present_q[ch], (t > w), "R3", $sformatf("ch%0d W=%0d tick %0d", ch, w, t));
                        chk(usable[ch], (t > w), "R9", "usable follows present");
                    end

                    // R2 / R5: short loss then restart
                    sig_ok[ch] = 1'b0;
                    @(negedge clk);
                    repeat (h) tick1();
                    chk(present_q[ch], 1'b1, "R2", $sformatf("short loss H=%0d", h));
                    chk(usable[ch], 1'b1, "R2", "usable during short loss");
                    chk(dev_latched[ch], 1'b0, "R2", "deviation during short loss");
                    sig_ok[ch] = 1'b1;
                    @(negedge clk);
                    chk(present_q[ch], 1'b1, "R5", "return in holdoff");

                    // R1 with a fresh count proves the R5 restart
                    sig_ok[ch] = 1'b0;
                    @(negedge clk);
                    for (int t = 1; t <= h + 1; t++) begin
                        tick1();
                        chk(present_q[ch], (t <= h), "R1", $sformatf("ch%0d H=%0d tick %0d", ch, h, t));
                    end

                    // R4: drop inside restore window restarts it
                    sig_ok[ch] = 1'b1;
                    @(negedge clk);
                    repeat (w) tick1();
                    sig_ok[ch] = 1'b0;
                    @(negedge clk);
                    chk(present_q[ch], 1'b0, "R4", "drop in restore");
                    sig_ok[ch] = 1'b1;
                    @(negedge clk);
                    repeat (w) tick1();
                    chk(present_q[ch], 1'b0, "R4", $sformatf("restarted W=%0d", w));
                    tick1();
                    chk(present_q[ch], 1'b1, "R4", "full window after restart");
                    others_idle(ch, "R11");
                end
            end
        end

        // Deviation tests on channel 0
        holdoff_len = '0; wtr_len = '0; sig_ok = 4'b0001;
        @(negedge clk);
        tick1();
        chk(present_q[0], 1'b1, "R3", "ch0 up for deviation tests");

        for (int d = 0; d < 4; d++) begin
            det_en = d[0]; sw_en = d[1];
            dev_bad[0] = 1'b1;
            @(negedge clk);
            dev_bad[0] = 1'b0;
            chk(dev_latched[0], (d == 3), "R6", $sformatf("enables %0d", d));
            chk(usable[0], (d != 3), "R9", "usable vs deviation");
            recover[0] = 1'b1;
            @(negedge clk);
            recover[0] = 1'b0;
            chk(dev_latched[0], 1'b0, "R7", "recover clears");
        end

        det_en = 1'b1; sw_en = 1'b1;
        dev_bad[0] = 1'b1;
        @(negedge clk);
        dev_bad[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(dev_latched[0], 1'b1, "R7", "persists after deviation gone");
        recover[1] = 1'b1;
        @(negedge clk);
        recover[1] = 1'b0;
        chk(dev_latched[0], 1'b1, "R11", "other channel recover");
        chk(dev_latched[1], 1'b0, "R8", "recover on normal ch1");
        det_en = 1'b0; sw_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(dev_latched[0], 1'b1, "R7", "persists with enables off");
        det_en = 1'b1; sw_en = 1'b1;
        recover[0] = 1'b1;
        @(negedge clk);
        recover[0] = 1'b0;
        chk(dev_latched[0], 1'b0, "R7", "own recover clears");

        // R8: recover while normal, then the collision
        recover[0] = 1'b1;
        @(negedge clk);
        recover[0] = 1'b0;
        chk(dev_latched[0], 1'b0, "R8", "recover when normal");
        chk(usable[0], 1'b1, "R8", "usable unchanged");
        dev_bad[0] = 1'b1; recover[0] = 1'b1;
        @(negedge clk);
        dev_bad[0] = 1'b0; recover[0] = 1'b0;
        chk(dev_latched[0], 1'b1, "R8", "fault wins collision");
        chk(usable[0], 1'b0, "R9", "usable low on fault");

        // R9: lost channel with normal status is unusable
        recover[0] = 1'b1;
        @(negedge clk);
        recover[0] = 1'b0;
        sig_ok[0] = 1'b0;
        @(negedge clk);
        tick1();
        chk(usable[0], 1'b0, "R9", "lost is unusable");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule